// File: doc/BRIEF.md
# Bridge Error Event Reporter

This block gathers error conditions raised while a two-port bus bridge forwards traffic, and turns them into an active-low system error signal on the primary side. Three kinds of event arrive as single-cycle strobes from the forwarding engines: a master abort seen during a posted write, a parity error flagged by the target bus during a posted write, and a master timeout on a delayed transaction. The other three kinds are produced inside the block. Each of three retry counters tracks one transaction class: posted write, delayed write and delayed read. A counter abandons its transaction after a parameterised number of target retries.

Every event is recorded in a sticky cause register, whether or not it is allowed to reach the error pin. Five of the six events can be suppressed one at a time through a disable register. The master timeout event has no disable bit. It reaches the pin only when an enable bit in a control register is set. A small address/write-strobe port reads and writes the three registers.

Top module: `brg_err_report`

## Requirements
- R1: After reset the cause, disable and control registers read zero and serrN is high.
- R2: Each class has its own retry counter: posted write is index 0, delayed write is index 1 and delayed read is index 2. A retry strobe for that class that would be retry number RETRY_LIMIT (default 2^24) since the last restart raises that class's abandon event, and the counter restarts from zero. No counter ever holds a value of RETRY_LIMIT or more.
- R3: A done strobe for a class returns its counter to zero. When retry and done arrive in the same cycle, done wins and the retry is not counted.
- R4: An event sets its cause bit at the next clock edge, even if the event is disabled. Cause bit positions: 0 posted-write master abort, 1 posted-write parity error, 2 posted-write abandon, 3 delayed-write abandon, 4 delayed-read failure, 5 master timeout.
- R5: Cause bits hold until software writes a 1 to that bit at address 0. A new event on a bit in the same cycle as its clear leaves the bit set.
- R6: serrN is low for exactly the one cycle after each clock edge that samples at least one enabled event. This holds even if the cause bit is already set. Events that coincide give a single low cycle.
- R7: Disable register bits [4:0] at address 1 line up with cause bits 0 to 4. A set bit keeps that event off serrN. Bits above 4 read zero.
- R8: Control bit 0 at address 2 enables master timeout onto serrN. The disable register has no effect on master timeout.
- R9: regRdata shows the register selected by regSel without delay: 0 cause, 1 disable, 2 control, 3 zero. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwMstAbort | input | 1 | Master abort strobe during a posted write |
| pwParErr | input | 1 | Target-bus parity error strobe during a posted write |
| mstTimeout | input | 1 | Master timeout strobe on a delayed transaction |
| retryStb | input | 3 | Target retry received, per class (0 posted write, 1 delayed write, 2 delayed read) |
| doneStb | input | 3 | Transaction completed, per class |
| regSel | input | 2 | Register select |
| regWr | input | 1 | Register write strobe |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data |
| serrN | output | 1 | System error output, active low |

## Verification
Two pairs of functions can collide in the same cycle. The first pair is a software clear of a cause bit and a fresh event on that same bit. The bench writes 1s to the abandon bits in the very cycle that the delayed-read counter is exhausted. It then checks that only the delayed-read bit survives and that serrN still pulses low. The second pair is a completion and a retry for the same class in one cycle. The bench issues them together when the counter is one retry short of its limit, then sends one more retry. No abandon event must follow, which shows the counter was cleared and not advanced.

// File: rtl/brg_err_pkg.sv
package brg_err_pkg;
  localparam int EV_N      = 6;
  localparam int MASKN     = 5;
  localparam int XFER_N    = 3;
  localparam int EV_PW_MA  = 0;
  localparam int EV_PW_PAR = 1;
  localparam int EV_XFER0  = 2;
  localparam int EV_MTO    = 5;

  typedef enum logic [1:0] {
    SEL_CAUSE   = 2'd0,
    SEL_DISABLE = 2'd1,
    SEL_CONTROL = 2'd2,
    SEL_NONE    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [EV_N-1:0] clrBits;
    logic [EV_N-1:0] reportEn;
  } ctrlStb_t;
endpackage

// File: rtl/brg_retry_cnt.sv
module brg_retry_cnt #(
  parameter int LIMIT = 1 << 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic retryStb,
  input  logic doneStb,
  output logic exhaust
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;
  logic atLast;

  assign atLast  = (cnt == LAST);
  assign exhaust = retryStb && !doneStb && atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (doneStb) begin
      cnt <= '0;
    end else if (retryStb) begin
      if (atLast) cnt <= '0;
      else        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/brg_err_ctrl.sv
module brg_err_ctrl
  import brg_err_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [EV_N-1:0]   statusQ,
  output logic [DATA_W-1:0] regRdata,
  output ctrlStb_t          stb
);
  logic [MASKN-1:0] disQ;
  logic             mtoEnQ;
  regSel_e          sel;

  assign sel = regSel_e'(regSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disQ   <= '0;
      mtoEnQ <= 1'b0;
    end else if (regWr) begin
      if (sel == SEL_DISABLE) disQ   <= regWdata[MASKN-1:0];
      if (sel == SEL_CONTROL) mtoEnQ <= regWdata[0];
    end
  end

  always_comb begin
    stb.clrBits  = (regWr && sel == SEL_CAUSE) ? regWdata[EV_N-1:0] : '0;
    stb.reportEn = {mtoEnQ, ~disQ};
  end

  always_comb begin
    regRdata = '0;
    unique case (sel)
      SEL_CAUSE:   regRdata[EV_N-1:0]  = statusQ;
      SEL_DISABLE: regRdata[MASKN-1:0] = disQ;
      SEL_CONTROL: regRdata[0]         = mtoEnQ;
      default:     regRdata            = '0;
    endcase
  end
endmodule

// File: rtl/brg_err_dp.sv
module brg_err_dp
  import brg_err_pkg::*;
#(
  parameter int RETRY_LIMIT = 1 << 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwMstAbort,
  input  logic              pwParErr,
  input  logic              mstTimeout,
  input  logic [XFER_N-1:0] retryStb,
  input  logic [XFER_N-1:0] doneStb,
  input  ctrlStb_t          stb,
  output logic [EV_N-1:0]   statusQ,
  output logic              serrN
);
  logic [XFER_N-1:0] exhaust;
  logic [EV_N-1:0]   events;

  for (genvar k = 0; k < XFER_N; k++) begin : gen_cnt
    brg_retry_cnt #(.LIMIT(RETRY_LIMIT)) u_cnt (
      .clk      (clk),
      .rstN     (rstN),
      .retryStb (retryStb[k]),
      .doneStb  (doneStb[k]),
      .exhaust  (exhaust[k])
    );
  end

  always_comb begin
    events                              = '0;
    events[EV_PW_MA]                    = pwMstAbort;
    events[EV_PW_PAR]                   = pwParErr;
    events[EV_XFER0 +: XFER_N]          = exhaust;
    events[EV_MTO]                      = mstTimeout;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      serrN   <= 1'b1;
    end else begin
      statusQ <= (statusQ & ~stb.clrBits) | events;
      serrN   <= ~|(events & stb.reportEn);
    end
  end
endmodule

// File: rtl/brg_err_report.sv
module brg_err_report
  import brg_err_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RETRY_LIMIT = 1 << 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwMstAbort,
  input  logic              pwParErr,
  input  logic              mstTimeout,
  input  logic [2:0]        retryStb,
  input  logic [2:0]        doneStb,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              serrN
);
  logic [EV_N-1:0] statusQ;
  ctrlStb_t        stb;

  brg_err_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .regWr    (regWr),
    .regWdata (regWdata),
    .statusQ  (statusQ),
    .regRdata (regRdata),
    .stb      (stb)
  );

  brg_err_dp #(.RETRY_LIMIT(RETRY_LIMIT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pwMstAbort (pwMstAbort),
    .pwParErr   (pwParErr),
    .mstTimeout (mstTimeout),
    .retryStb   (retryStb),
    .doneStb    (doneStb),
    .stb        (stb),
    .statusQ    (statusQ),
    .serrN      (serrN)
  );
endmodule

// File: rtl/brg_err_report_chk.sv
module brg_err_report_chk
  import brg_err_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwMstAbort,
  input logic              pwParErr,
  input logic              mstTimeout,
  input logic [2:0]        retryStb,
  input logic [1:0]        regSel,
  input logic              regWr,
  input logic [DATA_W-1:0] regWdata,
  input logic              serrN,
  input logic [EV_N-1:0]   statusQ,
  input logic [EV_N-1:0]   reportEn
);
  // R4
  abort_recorded_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwMstAbort |=> statusQ[EV_PW_MA]);

  // R5
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[EV_PW_MA] && !(regWr && regSel == 2'd0 && regWdata[0])) |=> statusQ[EV_PW_MA]);

  // R6
  parity_reported_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwParErr && reportEn[EV_PW_PAR]) |=> !serrN);

  // R6
  serr_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !serrN |-> $past(pwMstAbort || pwParErr || mstTimeout || (|retryStb)));

  // R8
  timeout_reported_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mstTimeout && reportEn[EV_MTO]) |=> !serrN);
endmodule

bind brg_err_report brg_err_report_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pwMstAbort (pwMstAbort),
  .pwParErr   (pwParErr),
  .mstTimeout (mstTimeout),
  .retryStb   (retryStb),
  .regSel     (regSel),
  .regWr      (regWr),
  .regWdata   (regWdata),
  .serrN      (serrN),
  .statusQ    (statusQ),
  .reportEn   (stb.reportEn)
);

// File: tb/brg_err_report_tb.sv
module brg_err_report_tb;
  localparam int LIM = 4;
  localparam int NV  = 34;

  typedef struct packed {
    logic       wr;
    logic [1:0] sel;
    logic [7:0] wd;
    logic       ma;
    logic       par;
    logic       to;
    logic [2:0] rt;
    logic [2:0] dn;
    logic       eN;
    logic [5:0] eS;
  } vec_t;

  // Fields: wr, sel, wd, ma, par, to, retry, done, expected serrN, expected cause
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd2, 8'h01, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 6'h00}, // 0  R8 enable timeout
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 6'h01}, // 1  R4 R6 abort
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 6'h01}, // 2  R6 one cycle
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 6'h01}, // 3  R6 already set
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 3'b000, 1'b0, 6'h03}, // 4  R4 parity
    '{1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 6'h02}, // 5  R5 clear bit0
    '{1'b1, 2'd1, 8'h02, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 6'h02}, // 6  R7 disable parity
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 3'b000, 1'b1, 6'h02}, // 7  R7 masked, R4 recorded
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, 1'b0, 6'h22}, // 8  R8 timeout enabled
    '{1'b1, 2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 6'h00}, // 9  R5 clear all
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000, 1'b1, 6'h00}, // 10 R2 retry 1
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000, 1'b1, 6'h00}, // 11 R2 retry 2
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000, 1'b1, 6'h00}, // 12 R2 retry 3
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000, 1'b0, 6'h04}, // 13 R2 limit reached
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000, 1'b1, 6'h04}, // 14 R2 restarted
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b000, 3'b001, 1'b1, 6'h04}, // 15 R3 done
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000, 1'b1, 6'h04}, // 16 R3
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000, 1'b1, 6'h04}, // 17 R3
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000, 1'b1, 6'h04}, // 18 R3 count 3
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b001, 1'b1, 6'h04}, // 19 R3 done wins
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000, 1'b1, 6'h04}, // 20 R3 no abandon
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b010, 3'b000, 1'b1, 6'h04}, // 21 R2 delayed write
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b010, 3'b000, 1'b1, 6'h04}, // 22 R2
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b010, 3'b000, 1'b1, 6'h04}, // 23 R2
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b010, 3'b000, 1'b0, 6'h0C}, // 24 R2 dw abandon
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b100, 3'b000, 1'b1, 6'h0C}, // 25 R2 delayed read
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b100, 3'b000, 1'b1, 6'h0C}, // 26 R2
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b100, 3'b000, 1'b1, 6'h0C}, // 27 R2
    '{1'b1, 2'd0, 8'h1C, 1'b0, 1'b0, 1'b0, 3'b100, 3'b000, 1'b0, 6'h10}, // 28 R5 set beats clear
    '{1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 6'h10}, // 29 R8 disable timeout
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, 1'b1, 6'h30}, // 30 R8 gated off
    '{1'b1, 2'd1, 8'h1F, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 6'h30}, // 31 R8 disable all
    '{1'b1, 2'd2, 8'h01, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 6'h30}, // 32 R8 enable again
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, 1'b0, 6'h30}  // 33 R8 mask ignored
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       pwMstAbort, pwParErr, mstTimeout;
  logic [2:0] retryStb, doneStb;
  logic [1:0] regSel;
  logic       regWr;
  logic [7:0] regWdata, regRdata;
  logic       serrN;
  int         nChk = 0;
  int         nBad = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  brg_err_report #(.DATA_W(8), .RETRY_LIMIT(LIM)) u_dut (
    .clk(clk), .rstN(rstN), .pwMstAbort(pwMstAbort), .pwParErr(pwParErr),
    .mstTimeout(mstTimeout), .retryStb(retryStb), .doneStb(doneStb),
    .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .serrN(serrN)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    regWr = 1'b0; regSel = 2'd0; regWdata = '0;
    pwMstAbort = 1'b0; pwParErr = 1'b0; mstTimeout = 1'b0;
    retryStb = '0; doneStb = '0;
  endtask

  task automatic applyVec(input vec_t v, input string tag);
    regWr = v.wr; regSel = v.sel; regWdata = v.wd;
    pwMstAbort = v.ma; pwParErr = v.par; mstTimeout = v.to;
    retryStb = v.rt; doneStb = v.dn;
    @(posedge clk);
    #3;
    idleInputs();
    #1;
    check({tag, " serrN"}, {7'b0, serrN}, {7'b0, v.eN});
    check({tag, " cause"}, regRdata, {2'b00, v.eS});
  endtask

  task automatic readReg(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    regSel = sel;
    #1;
    check(tag, regRdata, exp);
    regSel = 2'd0;
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] d);
    regWr = 1'b1; regSel = sel; regWdata = d;
    @(posedge clk);
    #3;
    idleInputs();
  endtask

  initial begin
    idleInputs();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    // R1 reset state
    check("R1 serrN", {7'b0, serrN}, 8'h01);
    readReg(2'd0, 8'h00, "R1 cause");
    readReg(2'd1, 8'h00, "R1 disable");
    readReg(2'd2, 8'h00, "R1 control");
    rstN = 1'b1;
    @(posedge clk);
    #3;

    for (int i = 0; i < NV; i++) begin
      applyVec(TBL[i], $sformatf("vec%0d", i));
    end

    // R9 readback of each register and the empty slot
    readReg(2'd1, 8'h1F, "R9 disable");
    readReg(2'd2, 8'h01, "R9 control");
    readReg(2'd3, 8'h00, "R9 empty slot");
    writeReg(2'd1, 8'hFF);
    readReg(2'd1, 8'h1F, "R7 upper disable bits");
    writeReg(2'd2, 8'hFE);
    readReg(2'd2, 8'h00, "R9 control bit0 only");
    writeReg(2'd2, 8'hFF);
    readReg(2'd2, 8'h01, "R9 control set");
    writeReg(2'd1, 8'h00);
    writeReg(2'd0, 8'hFF);
    readReg(2'd0, 8'h00, "R5 cleared");

    // R6 coinciding events give one low cycle
    applyVec('{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 3'b000, 3'b000, 1'b0, 6'h23}, "R6 together");
    applyVec('{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 6'h23}, "R6 release");

    // R1 reset in mid-run
    rstN = 1'b0;
    #2;
    check("R1 rerun serrN", {7'b0, serrN}, 8'h01);
    readReg(2'd0, 8'h00, "R1 rerun cause");
    readReg(2'd1, 8'h00, "R1 rerun disable");
    readReg(2'd2, 8'h00, "R1 rerun control");
    rstN = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule